// File: doc/BRIEF.md
# Logarithmic Rotate-Right Unit

This block rotates a data word to the right by a variable amount. Bits that leave the least significant end come back in at the most significant end, so no bit is lost and none is zero-filled. The amount is an unsigned control input that covers every rotation from zero up to one less than the word width. The default configuration is a 16-bit word with a 4-bit amount.

The unit is purely combinational. It is built as a chain of multiplexer stages, with one stage for each bit of the amount. Stage k either passes its word through unchanged or applies a fixed rewiring that rotates the word by 2^k places. No shift operator is used anywhere in the datapath.

The rotation is used by placing the word on `din` and the amount on `amt`. The rotated word appears on `dout` after the propagation delay. No clock is involved.

Top module: `ror_barrel`

## Requirements
- R1: When `amt` is 0, `dout` equals `din`.
- R2: For every input, bit i of `dout` equals bit ((i + amt) mod 16) of `din`. This is the same as (din >> amt) | (din << (16 - amt)), truncated to 16 bits.
- R3: With `din` = 16'hB573 and `amt` = 5, `dout` is 16'h9DAB.
- R4: The number of ones in `dout` always equals the number of ones in `din`.
- R5: When `amt` is a single power of two 2^k, `dout` is `din` rotated right by exactly 2^k. In particular, an amount of 8 swaps the two bytes.
- R6: `dout` follows a change on `din` or `amt` with no clock edge in between.
- R7: An amount of 15 gives the same result as a rotate left by one place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din  | input     | 16    | Word to be rotated |
| amt  | input     | 4     | Unsigned rotate-right distance |
| dout | output    | 16    | Rotated word |

## Verification
The checks assume that `din` and `amt` hold steady while the combinational paths settle. They also assume that `amt` never carries unknown values, because the checker indexes `din` with `amt` directly. The bench applies each pair of inputs and waits a fixed delay before it samples, so the outputs are never judged mid-transition. Every amount from 0 to 15 is paired with walking-one words, edge words and a large set of arithmetically spread words, so no out-of-range or undefined amount is ever applied.

// File: rtl/ror_barrel.sv
module ror_barrel #(
  parameter int W = 16,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stage [0:SW];

  assign stage[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int STEP = 2 ** k;
    logic [W-1:0] wired;
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign wired[i] = stage[k][(i + STEP) % W];
    end
    assign stage[k+1] = amt[k] ? wired : stage[k];
  end

  assign dout = stage[SW];

endmodule

// File: rtl/ror_barrel_chk.sv
module ror_barrel_chk #(
  parameter int W = 16,
  localparam int SW = $clog2(W)
) (
  input logic [W-1:0]  din,
  input logic [SW-1:0] amt,
  input logic [W-1:0]  dout
);

  always_comb begin
    if (amt == '0) AST_ZERO_IDENTITY: assert (dout == din); // R1
    AST_LSB_SOURCE: assert (dout[0] == din[amt]); // R2
    if (W == 16 && din == W'(16'hB573) && amt == SW'(5))
      AST_KNOWN_VECTOR: assert (dout == W'(16'h9DAB)); // R3
    AST_POP_KEPT: assert ($countones(dout) == $countones(din)); // R4
    if (amt == SW'(W / 2))
      AST_HALF_SWAP: assert (dout == {din[W/2-1:0], din[W-1:W/2]}); // R5
    if (amt == SW'(W - 1))
      AST_LEFT_ONE: assert (dout == {din[W-2:0], din[W-1]}); // R7
  end

endmodule

bind ror_barrel ror_barrel_chk #(.W(W)) chk_i (.din(din), .amt(amt), .dout(dout));

// File: tb/ror_barrel_tb.sv
module ror_barrel_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic [15:0] din;
  logic [3:0]  amt;
  logic [15:0] dout;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ror_barrel dut_i (.din(din), .amt(amt), .dout(dout));

  function automatic logic [15:0] ref_ror(logic [15:0] d, int a);
    logic [31:0] w;
    w = ({16'h0, d} >> a) | ({16'h0, d} << (16 - a));
    return w[15:0];
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s din=%h amt=%0d actual=%h expected=%h", req, din, amt, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] d, int a);
    din = d;
    amt = 4'(a);
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    din = '0;
    amt = '0;
    #3;
    check("R1", dout, 16'h0000);

    apply(16'hB573, 5);
    check("R3", dout, 16'h9DAB);

    for (int a = 0; a < 16; a++) begin
      for (int j = 0; j < 16; j++) begin
        apply(16'(1) << j, a);
        check("R2", dout, ref_ror(din, a));
      end
      apply(16'hFFFF, a);
      check("R4", dout, 16'hFFFF);
      apply(16'h0000, a);
      check("R4", dout, 16'h0000);
    end

    for (int i = 0; i < 1024; i++) begin
      logic [15:0] d;
      d = 16'(i * 40503) ^ 16'(i * 7 + 3);
      for (int a = 0; a < 16; a++) begin
        apply(d, a);
        check("R2", dout, ref_ror(d, a));
        total++;
        if ($countones(dout) != $countones(d)) begin
          bad++;
          $display("FAIL R4 actual=%0d expected=%0d", $countones(dout), $countones(d));
        end
      end
      apply(d, 0);
      check("R1", dout, d);
      apply(d, 15);
      check("R7", dout, {d[14:0], d[15]});
    end

    for (int k = 0; k < 4; k++) begin
      apply(16'hC3A5, 1 << k);
      check("R5", dout, ref_ror(16'hC3A5, 1 << k));
    end
    apply(16'h12AB, 8);
    check("R5", dout, 16'hAB12);

    @(posedge clk);
    #(CLK_PERIOD/4);
    amt = 4'd3;
    din = 16'h0001;
    #1;
    check("R6", dout, 16'h2000);
    din = 16'h8000;
    #1;
    check("R6", dout, 16'h1000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule